// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Character Buffer

This block takes one asynchronous serial input line and turns it into characters. A character starts with a low start bit. Data bits follow, least significant first. An optional parity bit comes next, then one or two high stop bits. Bit timing comes from a one-cycle sampling enable that pulses at sixteen times the bit rate. Each start edge realigns the timing, and every bit is taken at its midpoint.

Each finished character is written, together with its parity-error and framing-error flags, into a 16-entry first-in first-out buffer. The host reads the buffer through a valid/ready pop port while reception continues. The host picks the frame format through four static configuration inputs. A character that finishes while the buffer is full is thrown away, and a sticky overrun flag is set until the host clears it.

Top module: `serial_rx_fifo`

## Requirements
- R1: A character starts only when the line goes low after it has been seen high while idle. A line that stays low after a character starts nothing further until it has been high again.
- R2: If the line is high again at the start bit's midpoint (the 8th sampling pulse, counting the pulse that saw the low as the 1st), the block returns to idle and stores nothing.
- R3: Data bits are taken every 16 sampling pulses after the start-bit midpoint. The first bit received goes to bit 0 of `pop_data`. With `cfg_len7`=0, eight bits are stored.
- R4: With `cfg_len7`=1, seven data bits are received and bit 7 of the stored character is 0.
- R5: With `cfg_par_en`=1, one parity bit follows the data. `pop_perr` is 1 when the parity bit does not give an even count of ones over data plus parity (`cfg_par_odd`=0), or an odd count (`cfg_par_odd`=1). With `cfg_par_en`=0 there is no parity bit and `pop_perr` is 0.
- R6: One stop bit is expected, or two when `cfg_stop2`=1. `pop_ferr` is 1 when any expected stop bit is sampled low.
- R7: The buffer holds up to 16 characters, which come out in arrival order. `pop_valid` is 1 while it is not empty. A character is removed in a cycle where `pop_valid` and `pop_ready` are both 1. While it is not removed, the head character stays unchanged.
- R8: A character that finishes while 16 are held is dropped and `ovr_flag` is set. The flag stays set until `ovr_clear` is pulsed.
- R9: After reset the buffer is empty, `pop_valid` is 0 and `ovr_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len7 | input | 1 | 1: seven data bits, 0: eight |
| cfg_par_en | input | 1 | 1: parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_stop2 | input | 1 | 1: two stop bits |
| pop_ready | input | 1 | Host takes the head character |
| ovr_clear | input | 1 | Clears the overrun flag |
| pop_valid | output | 1 | Buffer holds a character |
| pop_data | output | 8 | Head character |
| pop_perr | output | 1 | Parity error of the head character |
| pop_ferr | output | 1 | Framing error of the head character |
| ovr_flag | output | 1 | Sticky overrun indication |

## Verification
The assertions assume that the configuration inputs stay fixed for the whole of any character, and that `tick16` is a single-cycle pulse spaced at least two clocks apart. The stimulus meets both conditions. It changes the format only while the line is idle between characters, and it produces `tick16` from a free-running divide-by-four. Each bit is held for exactly 16 sampling pulses, so the midpoint sample lands far from any line transition, even with the two-stage input synchroniser and an unknown pulse phase.

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int OSR   = 16,
  parameter int MID   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       cfg_len7,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  input  logic       pop_ready,
  input  logic       ovr_clear,
  output logic       pop_valid,
  output logic [7:0] pop_data,
  output logic       pop_perr,
  output logic       pop_ferr,
  output logic       ovr_flag
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(OSR);
  localparam int EW = 10;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2} st_t;

  st_t            st;
  logic           rx_m, rx_s, armed;
  logic [CW-1:0]  cnt;
  logic [2:0]     bitn;
  logic [7:0]     sh;
  logic           par_bit, ferr_acc;
  logic [AW:0]    wr_ptr, rd_ptr;
  logic [EW-1:0]  mem [DEPTH];

  logic       go, mid_start, bit_end, data_last, push_evt, push, pop, full, empty;
  logic       w_perr, w_ferr;
  logic [7:0] rx_byte;

  assign go        = (st == S_IDLE) && tick16 && !rx_s && armed;
  assign mid_start = tick16 && (cnt == CW'(MID - 1));
  assign bit_end   = tick16 && (cnt == CW'(OSR - 1));
  assign data_last = (bitn == (cfg_len7 ? 3'd6 : 3'd7));
  assign rx_byte   = cfg_len7 ? {1'b0, sh[7:1]} : sh;
  assign push_evt  = bit_end && (((st == S_STOP1) && !cfg_stop2) || (st == S_STOP2));
  assign w_ferr    = ferr_acc | ~rx_s;
  assign w_perr    = cfg_par_en & (^rx_byte ^ par_bit ^ cfg_par_odd);

  assign empty     = (wr_ptr == rd_ptr);
  assign full      = ((wr_ptr ^ rd_ptr) == {1'b1, {AW{1'b0}}});
  assign push      = push_evt && !full;
  assign pop_valid = !empty;
  assign pop       = pop_valid && pop_ready;
  assign {pop_perr, pop_ferr, pop_data} = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= (st == S_IDLE) ? ((armed | rx_s) & !go) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      sh       <= '0;
      par_bit  <= 1'b0;
      ferr_acc <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (go) begin
          st       <= S_START;
          cnt      <= CW'(1);
          ferr_acc <= 1'b0;
          par_bit  <= 1'b0;
        end
        S_START: if (mid_start) begin
          cnt  <= '0;
          bitn <= '0;
          st   <= rx_s ? S_IDLE : S_DATA;
        end else if (tick16) cnt <= cnt + 1'b1;
        S_DATA: if (bit_end) begin
          cnt  <= '0;
          sh   <= {rx_s, sh[7:1]};
          bitn <= bitn + 1'b1;
          if (data_last) st <= cfg_par_en ? S_PAR : S_STOP1;
        end else if (tick16) cnt <= cnt + 1'b1;
        S_PAR: if (bit_end) begin
          cnt     <= '0;
          par_bit <= rx_s;
          st      <= S_STOP1;
        end else if (tick16) cnt <= cnt + 1'b1;
        S_STOP1: if (bit_end) begin
          cnt <= '0;
          if (cfg_stop2) begin
            ferr_acc <= ~rx_s;
            st       <= S_STOP2;
          end else st <= S_IDLE;
        end else if (tick16) cnt <= cnt + 1'b1;
        S_STOP2: if (bit_end) begin
          cnt <= '0;
          st  <= S_IDLE;
        end else if (tick16) cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[AW-1:0]] <= {w_perr, w_ferr, rx_byte};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      ovr_flag <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      if (push_evt && full) ovr_flag <= 1'b1;
      else if (ovr_clear)   ovr_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_fifo_chk.sv
module serial_rx_fifo_chk #(
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     pop_valid,
  input logic                     pop_ready,
  input logic [7:0]               pop_data,
  input logic                     ovr_flag,
  input logic                     ovr_clear,
  input logic                     push,
  input logic                     push_evt,
  input logic                     full,
  input logic [7:0]               rx_byte,
  input logic                     cfg_len7,
  input logic                     cfg_par_en,
  input logic                     w_perr,
  input logic [$clog2(DEPTH):0]   wr_ptr,
  input logic [$clog2(DEPTH):0]   rd_ptr
);
  localparam int AW = $clog2(DEPTH);
  logic [AW:0] level;
  assign level = wr_ptr - rd_ptr;

  AST_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) pop_valid && !pop_ready |=> pop_valid && $stable(pop_data));  // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) level <= (AW+1)'(DEPTH));  // R7
  AST_MSB_ZERO_7BIT: assert property (@(posedge clk) disable iff (!rst_n) push && cfg_len7 |-> !rx_byte[7]);  // R4
  AST_NO_PERR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) push && !cfg_par_en |-> !w_perr);  // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ovr_flag && !ovr_clear |=> ovr_flag);  // R8
  AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n) push_evt && full |=> ovr_flag);  // R8
endmodule

bind serial_rx_fifo serial_rx_fifo_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/serial_rx_fifo_tb.sv
`timescale 1ns/1ps
module serial_rx_fifo_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic cfg_len7 = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_stop2 = 0;
  logic pop_ready = 0, ovr_clear = 0;
  logic pop_valid, pop_perr, pop_ferr, ovr_flag;
  logic [7:0] pop_data;
  int checks = 0, errors = 0;
  logic [1:0] tdiv = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= tdiv + 1'b1;
    tick16 <= (tdiv == 2'd3);
  end

  serial_rx_fifo dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    @(negedge clk) rxd = b;
    repeat (63) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_s1, input bit bad_s2);
    logic [7:0] m;
    m = cfg_len7 ? {1'b0, d[6:0]} : d;
    drive_bit(1'b0);
    for (int i = 0; i < (cfg_len7 ? 7 : 8); i++) drive_bit(d[i]);
    if (cfg_par_en) drive_bit((^m) ^ cfg_par_odd ^ bad_par);
    drive_bit(!bad_s1);
    if (cfg_stop2) drive_bit(!bad_s2);
    drive_bit(1'b1);
  endtask

  task automatic expect_char(input logic [7:0] d, input bit pe, input bit fe, input string req);
    int w = 0;
    @(negedge clk);
    while (!pop_valid && w < 2000) begin @(negedge clk); w++; end
    chk(pop_valid, req, pop_valid, 1);
    chk(pop_data == d, req, pop_data, d);
    chk(pop_perr == pe, {req, " perr"}, pop_perr, pe);
    chk(pop_ferr == fe, {req, " ferr"}, pop_ferr, fe);
    pop_ready = 1'b1;
    @(negedge clk) pop_ready = 1'b0;
  endtask

  task automatic set_fmt(input bit l7, input bit pe, input bit po, input bit s2);
    cfg_len7 = l7; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
  endtask

  task automatic t_reset;
    chk(!pop_valid, "R9 valid", pop_valid, 0);
    chk(!ovr_flag, "R9 ovr", ovr_flag, 0);
  endtask

  task automatic t_data8;
    set_fmt(0, 0, 0, 0);
    send(8'hA5, 0, 0, 0); expect_char(8'hA5, 0, 0, "R3 8N1 A5");
    send(8'h01, 0, 0, 0); expect_char(8'h01, 0, 0, "R3 8N1 01");
    send(8'h80, 0, 0, 0); expect_char(8'h80, 0, 0, "R3 8N1 80");
  endtask

  task automatic t_data7;
    set_fmt(1, 0, 0, 0);
    send(8'hD3, 0, 0, 0); expect_char(8'h53, 0, 0, "R4 7bit");
    set_fmt(1, 1, 1, 0);
    send(8'hFF, 0, 0, 0); expect_char(8'h7F, 0, 0, "R4 7bit odd par");
  endtask

  task automatic t_parity;
    set_fmt(0, 1, 0, 0);
    send(8'h37, 0, 0, 0); expect_char(8'h37, 0, 0, "R5 even ok");
    send(8'h37, 1, 0, 0); expect_char(8'h37, 1, 0, "R5 even bad");
    set_fmt(0, 1, 1, 0);
    send(8'h36, 0, 0, 0); expect_char(8'h36, 0, 0, "R5 odd ok");
    send(8'h36, 1, 0, 0); expect_char(8'h36, 1, 0, "R5 odd bad");
  endtask

  task automatic t_stop;
    set_fmt(0, 0, 0, 1);
    send(8'h5A, 0, 0, 0); expect_char(8'h5A, 0, 0, "R6 two stop ok");
    send(8'h5A, 0, 1, 0); expect_char(8'h5A, 0, 1, "R6 first stop low");
    send(8'h5A, 0, 0, 1); expect_char(8'h5A, 0, 1, "R6 second stop low");
    set_fmt(0, 0, 0, 0);
    send(8'hC3, 0, 1, 0); expect_char(8'hC3, 0, 1, "R6 one stop low");
  endtask

  task automatic t_glitch;
    set_fmt(0, 0, 0, 0);
    @(negedge clk) rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (300) @(negedge clk);
    chk(!pop_valid, "R2 glitch stored", pop_valid, 0);
    send(8'h3C, 0, 0, 0); expect_char(8'h3C, 0, 0, "R2 frame after glitch");
  endtask

  task automatic t_hold_low;
    set_fmt(0, 0, 0, 0);
    @(negedge clk) rxd = 1'b0;
    repeat (64 * 24) @(negedge clk);
    expect_char(8'h00, 0, 1, "R1 held low one char");
    repeat (64 * 4) @(negedge clk);
    chk(!pop_valid, "R1 no restart while low", pop_valid, 0);
    rxd = 1'b1;
    repeat (128) @(negedge clk);
    send(8'h96, 0, 0, 0); expect_char(8'h96, 0, 0, "R1 start after high");
  endtask

  task automatic t_overrun;
    logic [7:0] d0;
    set_fmt(0, 0, 0, 0);
    for (int i = 0; i < 16; i++) send(8'(i * 7 + 1), 0, 0, 0);
    chk(!ovr_flag, "R8 no ovr at 16", ovr_flag, 0);
    send(8'hEE, 0, 0, 0);
    chk(ovr_flag, "R8 ovr set", ovr_flag, 1);
    d0 = pop_data;
    repeat (10) @(negedge clk);
    chk(pop_data == d0 && pop_valid, "R7 head held", pop_data, d0);
    for (int i = 0; i < 16; i++) expect_char(8'(i * 7 + 1), 0, 0, "R7 order");
    chk(!pop_valid, "R8 dropped char absent", pop_valid, 0);
    chk(ovr_flag, "R8 sticky", ovr_flag, 1);
    ovr_clear = 1'b1;
    @(negedge clk) ovr_clear = 1'b0;
    @(negedge clk);
    chk(!ovr_flag, "R8 cleared", ovr_flag, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (200) @(negedge clk);
    t_reset;
    t_data8;
    t_data7;
    t_parity;
    t_stop;
    t_glitch;
    t_hold_low;
    t_overrun;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule